// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is an 8-bit up/down timer that produces a symmetric, centre-aligned PWM waveform on two channels. On every enabled tick the count moves one step towards its current end point. It climbs from zero to a turn-around value (TOP), then falls back to zero, and repeats. A mode input picks TOP. It is either the full-scale value 255 or the active compare value of channel A. In the second case channel A is used up as the period setting, so its pin stays low and only channel B produces PWM.

Each channel compares the live count with its active compare value. A match on the rising slope drives the pin one way, and a match on the falling slope drives it the other way. A single polarity input chooses which way. The compare inputs are double-buffered: a new value is copied into the active register only on a tick while the count is at TOP, so a period is never cut short.

Three sticky flags record events: the count arriving at zero, and a compare match on each channel. Each flag is cleared only by its own one-cycle clear strobe. A tick-enable input gates all counting and pin activity, so an external prescaler can set the rate.

Top module: `pcpwm_timer`

## Requirements
- R1: On each enabled tick the count rises by one while heading up and falls by one while heading down. It travels 0 → TOP → 0 with one full period lasting 2·TOP ticks (TOP > 0).
- R2: With `top_sel` = 0, TOP is 255. With `top_sel` = 1, TOP is the active (buffered) compare value of channel A.
- R3: The count holds the value TOP for exactly one tick. The next value is TOP−1 and the count keeps falling after that.
- R4: In non-inverting mode (`invert` = 0), a match while heading up drives the pin low and a match while heading down drives it high. The pin changes in the cycle after the matching tick. For 0 < c < TOP the pin is high for 2·c cycles of each period.
- R5: In inverting mode (`invert` = 1), the actions of R4 are swapped. For 0 < c < TOP the pin is high for 2·TOP − 2·c cycles of each period.
- R6: A compare value equal to TOP gives a pin that is constantly low (non-inverting) or constantly high (inverting). A compare value of 0 gives the opposite constant level.
- R7: A compare input is copied into the channel's active register only on a tick where the count is at or above TOP. Before that copy, matches use the previous active value.
- R8: `ovf_flag` is set when the count steps from a non-zero value to 0. It becomes visible in the same cycle that `count` shows 0.
- R9: A compare match on a tick sets that channel's flag. The flag is visible in the cycle after the matching count.
- R10: A flag stays set until its own clear strobe is high for a cycle. A set in the same cycle wins over the clear.
- R11: While `tick_en` is low, the count, the direction and both pins hold their values.
- R12: Synchronous reset makes the count 0, the direction up, all flags 0, both pins low and both active compare values 0.
- R13: With `top_sel` = 1, `pwm_a` is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timer tick enable |
| top_sel | input | 1 | 0: TOP = 255, 1: TOP = channel A active compare |
| invert | input | 1 | 0: non-inverting, 1: inverting pin action |
| cmp_a | input | 8 | Channel A compare input (buffered) |
| cmp_b | input | 8 | Channel B compare input (buffered) |
| clr_ovf | input | 1 | One-cycle clear of the overflow flag |
| clr_cmp_a | input | 1 | One-cycle clear of channel A compare flag |
| clr_cmp_b | input | 1 | One-cycle clear of channel B compare flag |
| pwm_a | output | 1 | Channel A PWM pin |
| pwm_b | output | 1 | Channel B PWM pin |
| count | output | 8 | Live count value |
| ovf_flag | output | 1 | Count-reached-zero flag |
| cmp_flag_a | output | 1 | Channel A match flag |
| cmp_flag_b | output | 1 | Channel B match flag |

## Verification
Eight table rows combine both TOP sources and both polarities with compare values in the interior, at zero and at TOP. For each row the bench measures one full period and the high time of each pin. The period length separates a fixed TOP from a compare-A TOP. The high time separates a rising-slope clear from a falling-slope clear, and shows whether the end-point values produce a steady level or a glitch. A mid-period rewrite of channel B's compare value, followed by flag probes on both slopes, shows whether the old value stays active until TOP. Directed steps around the turn-around, the zero crossing and a gated tick check the single-tick dwell at TOP, the flag timing and the hold behaviour.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_t;

    typedef enum logic {
        POL_NONINV = 1'b0,
        POL_INV    = 1'b1
    } out_pol_t;

    typedef enum logic {
        TOP_FIXED = 1'b0,
        TOP_CMPA  = 1'b1
    } top_src_t;

    // Per-cycle view of the counter shared with the channels
    typedef struct packed {
        logic tick;          // enabled tick this cycle
        dir_t dir;           // direction of the current count value
        logic at_top;        // count at (or past) TOP
        logic reach_bottom;  // this tick moves the count onto zero
    } cnt_status_t;

    // Pin level written on a compare match
    function automatic logic match_level(dir_t d, out_pol_t p);
        return (d == DIR_DOWN) ^ (p == POL_INV);
    endfunction

endpackage

// File: rtl/pcpwm_counter.sv
module pcpwm_counter
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] count_o,
    output cnt_status_t  status_o
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt_q, cnt_d;
    dir_t         dir_q, dir_d;

    always_comb begin
        cnt_d = cnt_q;
        dir_d = dir_q;
        if (tick_en) begin
            case (dir_q)
                DIR_UP: begin
                    if (cnt_q >= top_val) begin
                        if (top_val == ZERO) begin
                            cnt_d = ZERO;
                        end else begin
                            cnt_d = cnt_q - ONE;
                            dir_d = DIR_DOWN;
                        end
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                DIR_DOWN: begin
                    if (cnt_q == ZERO) begin
                        if (top_val == ZERO) begin
                            cnt_d = ZERO;
                        end else begin
                            cnt_d = ONE;
                            dir_d = DIR_UP;
                        end
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: begin
                    cnt_d = cnt_q;
                    dir_d = dir_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ZERO;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    assign count_o               = cnt_q;
    assign status_o.tick         = tick_en;
    assign status_o.dir          = dir_q;
    assign status_o.at_top       = (cnt_q >= top_val);
    assign status_o.reach_bottom = tick_en && (cnt_q != ZERO) && (cnt_d == ZERO);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(cnt_q) && $stable(dir_q));  // R11

    AST_RISE_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick_en && dir_q == DIR_UP && cnt_q < top_val) |=> cnt_q == $past(cnt_q) + ONE);  // R1

    AST_TOP_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
        (tick_en && dir_q == DIR_UP && cnt_q == top_val && top_val != ZERO)
        |=> (dir_q == DIR_DOWN) && (cnt_q == $past(cnt_q) - ONE));  // R3

endmodule

// File: rtl/pcpwm_channel.sv
module pcpwm_channel
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_status_t  st,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp_in,
    input  out_pol_t     pol,
    input  logic         force_low,
    output logic [W-1:0] act_o,
    output logic         match_o,
    output logic         pwm_o
);

    logic [W-1:0] act_q;
    logic         pin_q;

    assign match_o = st.tick && (count == act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            pin_q <= 1'b0;
        end else begin
            if (st.tick && st.at_top) begin
                act_q <= cmp_in;
            end
            if (match_o) begin
                pin_q <= match_level(st.dir, pol);
            end
        end
    end

    assign act_o = act_q;
    assign pwm_o = force_low ? 1'b0 : pin_q;

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(st.tick && st.at_top) |=> $stable(act_q));  // R7

    AST_UP_MATCH_NONINV: assert property (@(posedge clk) disable iff (rst)
        (match_o && st.dir == DIR_UP && pol == POL_NONINV) |=> !pin_q);  // R4

    AST_DOWN_MATCH_INV: assert property (@(posedge clk) disable iff (rst)
        (match_o && st.dir == DIR_DOWN && pol == POL_INV) |=> !pin_q);  // R5

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !match_o |=> $stable(pin_q));  // R6

endmodule

// File: rtl/pcpwm_flag.sv
module pcpwm_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (q_o && !clr_i) |=> q_o);  // R10

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);  // R9

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         top_sel,
    input  logic         invert,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         clr_ovf,
    input  logic         clr_cmp_a,
    input  logic         clr_cmp_b,
    output logic         pwm_a,
    output logic         pwm_b,
    output logic [W-1:0] count,
    output logic         ovf_flag,
    output logic         cmp_flag_a,
    output logic         cmp_flag_b
);

    localparam int             NCH     = 2;
    localparam int             NFLAG   = NCH + 1;
    localparam logic [W-1:0]   TOP_MAX = '1;

    top_src_t    src;
    out_pol_t    pol;
    cnt_status_t st;
    logic [W-1:0] top_val;

    logic [W-1:0] cmp_in    [NCH];
    logic [W-1:0] act       [NCH];
    logic         match     [NCH];
    logic         pin       [NCH];
    logic         force_off [NCH];
    logic         fl_set    [NFLAG];
    logic         fl_clr    [NFLAG];
    logic         fl_q      [NFLAG];

    assign src     = top_src_t'(top_sel);
    assign pol     = out_pol_t'(invert);
    assign top_val = (src == TOP_CMPA) ? act[0] : TOP_MAX;

    always_comb begin
        cmp_in[0]    = cmp_a;
        cmp_in[1]    = cmp_b;
        force_off[0] = (src == TOP_CMPA);
        force_off[1] = 1'b0;
        fl_set[0]    = st.reach_bottom;
        fl_clr[0]    = clr_ovf;
        fl_clr[1]    = clr_cmp_a;
        fl_clr[2]    = clr_cmp_b;
        for (int c = 0; c < NCH; c++) begin
            fl_set[c+1] = match[c];
        end
    end

    pcpwm_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .top_val  (top_val),
        .count_o  (count),
        .status_o (st)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pcpwm_channel #(.W(W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .st        (st),
            .count     (count),
            .cmp_in    (cmp_in[g]),
            .pol       (pol),
            .force_low (force_off[g]),
            .act_o     (act[g]),
            .match_o   (match[g]),
            .pwm_o     (pin[g])
        );
    end

    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
        pcpwm_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set_i (fl_set[f]),
            .clr_i (fl_clr[f]),
            .q_o   (fl_q[f])
        );
    end

    assign pwm_a      = pin[0];
    assign pwm_b      = pin[1];
    assign ovf_flag   = fl_q[0];
    assign cmp_flag_a = fl_q[1];
    assign cmp_flag_b = fl_q[2];

    AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> (count == '0));  // R8

    AST_B_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_flag_b) |-> ($past(count) == $past(act[1])));  // R9

    AST_A_PIN_OFF: assert property (@(posedge clk) disable iff (rst)
        ($past(top_sel) && top_sel && $past(src) == TOP_CMPA) |-> !pwm_a);  // R13

endmodule

// File: tb/test_pcpwm_timer.sv
module test_pcpwm_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       top_sel = 1'b0;
    logic       invert = 1'b0;
    logic [7:0] cmp_a = 8'd0;
    logic [7:0] cmp_b = 8'd0;
    logic       clr_ovf = 1'b0;
    logic       clr_cmp_a = 1'b0;
    logic       clr_cmp_b = 1'b0;
    logic       pwm_a, pwm_b, ovf_flag, cmp_flag_a, cmp_flag_b;
    logic [7:0] count;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] prev_cnt = 8'd0;

    always #2.5 clk = ~clk;

    pcpwm_timer #(.W(8)) i_pcpwm_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .top_sel(top_sel),
        .invert(invert), .cmp_a(cmp_a), .cmp_b(cmp_b), .clr_ovf(clr_ovf),
        .clr_cmp_a(clr_cmp_a), .clr_cmp_b(clr_cmp_b), .pwm_a(pwm_a),
        .pwm_b(pwm_b), .count(count), .ovf_flag(ovf_flag),
        .cmp_flag_a(cmp_flag_a), .cmp_flag_b(cmp_flag_b)
    );

    typedef struct packed {
        logic       tsel;
        logic       inv;
        logic [7:0] ca;
        logic [7:0] cb;
        logic [9:0] per;
        logic [9:0] a_hi;
        logic [9:0] b_hi;
    } vec_t;

    // period = 2*TOP; high time from R4/R5/R6/R13
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 8'd64,  8'd128, 10'd510, 10'd128, 10'd256},
        '{1'b0, 1'b1, 8'd10,  8'd200, 10'd510, 10'd490, 10'd110},
        '{1'b1, 1'b0, 8'd100, 8'd30,  10'd200, 10'd0,   10'd60 },
        '{1'b1, 1'b1, 8'd100, 8'd30,  10'd200, 10'd0,   10'd140},
        '{1'b0, 1'b0, 8'd255, 8'd0,   10'd510, 10'd0,   10'd510},
        '{1'b0, 1'b1, 8'd255, 8'd0,   10'd510, 10'd510, 10'd0  },
        '{1'b1, 1'b0, 8'd50,  8'd50,  10'd100, 10'd0,   10'd0  },
        '{1'b1, 1'b1, 8'd40,  8'd1,   10'd80,  10'd0,   10'd78 }
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        prev_cnt = count;
        @(negedge clk);
    endtask

    task automatic wait_val(input logic [7:0] v, input bit rising);
        for (int i = 0; i < 2000; i++) begin
            step();
            if (count == v && ((count > prev_cnt) == rising)) return;
        end
    endtask

    task automatic wait_zero();
        for (int i = 0; i < 2000; i++) begin
            step();
            if (count == 8'd0) return;
        end
    endtask

    task automatic measure(output int per, output int ahi, output int bhi);
        per = 0; ahi = 0; bhi = 0;
        wait_zero();
        do begin
            ahi += int'(pwm_a);
            bhi += int'(pwm_b);
            step();
            per++;
        end while (count != 8'd0 && per < 1000);
    endtask

    initial begin
        int per, ahi, bhi;
        logic [7:0] held_cnt;
        logic held_pin;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        // R12: reset state
        chk("R12 count after reset", count, 0);
        chk("R12 flags after reset", {ovf_flag, cmp_flag_a, cmp_flag_b}, 0);
        chk("R12 pins after reset", {pwm_a, pwm_b}, 0);
        // R11: no ticks, no movement
        repeat (10) step();
        chk("R11 count holds with tick_en low", count, 0);

        tick_en = 1'b1;
        foreach (VECS[k]) begin
            top_sel = VECS[k].tsel;
            invert  = VECS[k].inv;
            cmp_a   = VECS[k].ca;
            cmp_b   = VECS[k].cb;
            repeat (1600) step();
            measure(per, ahi, bhi);
            chk($sformatf("R1 R2 period vec%0d", k), per, int'(VECS[k].per));
            chk($sformatf("R4 R5 R6 R13 pwm_a high vec%0d", k), ahi, int'(VECS[k].a_hi));
            chk($sformatf("R4 R5 R6 pwm_b high vec%0d", k), bhi, int'(VECS[k].b_hi));
        end

        // R3 / R2: fixed TOP dwell
        top_sel = 1'b0; invert = 1'b0; cmp_a = 8'd64; cmp_b = 8'd50;
        repeat (1600) step();
        wait_val(8'd254, 1'b1);
        step();
        chk("R2 R3 count reaches 255", count, 255);
        step();
        chk("R3 one tick at TOP then 254", count, 254);

        // R11: gated tick mid-run
        wait_val(8'd120, 1'b0);
        tick_en = 1'b0;
        held_cnt = count;
        held_pin = pwm_b;
        repeat (20) step();
        chk("R11 count frozen", count, held_cnt);
        chk("R11 pwm_b frozen", pwm_b, held_pin);
        tick_en = 1'b1;

        // R8 / R10: overflow flag
        wait_val(8'd100, 1'b1);
        clr_ovf = 1'b1;
        step();
        clr_ovf = 1'b0;
        step();
        chk("R10 clear drops ovf_flag", ovf_flag, 0);
        wait_zero();
        chk("R8 ovf_flag with count 0", ovf_flag, 1);
        repeat (5) step();
        chk("R10 ovf_flag sticky", ovf_flag, 1);

        // R7 / R9: double-buffered compare B
        wait_val(8'd10, 1'b1);
        cmp_b = 8'd200;
        clr_cmp_b = 1'b1;
        step();
        clr_cmp_b = 1'b0;
        wait_val(8'd60, 1'b1);
        chk("R7 old compare still active before TOP", cmp_flag_b, 1);
        wait_val(8'd150, 1'b0);
        clr_cmp_b = 1'b1;
        step();
        clr_cmp_b = 1'b0;
        wait_val(8'd30, 1'b0);
        chk("R7 new compare active after TOP", cmp_flag_b, 0);
        wait_val(8'd200, 1'b1);
        chk("R9 flag not yet set at matching count", cmp_flag_b, 0);
        step();
        chk("R9 flag set cycle after match", cmp_flag_b, 1);

        // R12: reset mid-run
        wait_val(8'd77, 1'b1);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R12 count cleared by reset", count, 0);
        chk("R12 flags cleared by reset", {ovf_flag, cmp_flag_a, cmp_flag_b}, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule